// File: doc/BRIEF.md
# Address Stream Prefetch Buffer

This block takes an ordered run of predicted block addresses and fetches their data ahead of demand into a small fully associative buffer that sits beside the cache. A producer pushes addresses one per cycle. The push that opens a new stream carries a restart flag, so one trigger can queue a long run of addresses. The queue hands addresses to memory strictly in arrival order. Each request carries the slot number it will fill, and memory returns the data tagged with that same slot.

Fetches are paced by consumption, not by a fixed prefetch degree. Requests still in flight and filled entries that have not yet been consumed share one lookahead budget. Issue pauses while the budget is used up. Each processor hit removes its entry and returns one unit of budget, so the fetch rate follows the rate at which the processor uses streamed blocks. When a new stream starts, the filled entries of older streams stop counting against the budget. They stay readable until their slots are needed. When every slot is occupied, the oldest filled entry is replaced.

A processor lookup returns its answer in the following cycle. The answer is a hit with data (the entry is then freed), a pending indication when the block is still on its way from memory, or a miss. After a pending answer, the requester repeats the lookup once the fill has landed.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: Queued addresses are sent on `mem_req_addr` in exactly the order they were pushed.
- R2: A push with `strm_restart` high discards every queued address not yet sent, leaves the pushed address as the only queued one, and no queued address is sent in that cycle.
- R3: A push without restart while the queue already holds QUEUE_DEPTH addresses is dropped and is never requested.
- R4: The number of requests in flight plus filled, unconsumed entries of the current stream never exceeds LOOKAHEAD (default 8). Issue stalls at that limit, and each hit lets exactly one more request go out.
- R5: A lookup that matches a filled entry answers `lk_hit` with that entry's data in the next cycle and frees the entry, so a repeated lookup of the same address misses.
- R6: A lookup that matches a request still in flight answers `lk_pend` in the next cycle and keeps the slot. After the fill, the same lookup hits.
- R7: A lookup that matches nothing answers `lk_miss` in the next cycle. Exactly one of hit, pend and miss is raised for each lookup, and none is raised without one.
- R8: When no slot is free, a new request replaces the filled entry allocated earliest. Slots with a request in flight are never replaced.
- R9: After a restart, entries filled before it no longer count toward LOOKAHEAD but still hit until they are replaced.
- R10: After reset, no request is sent, no lookup answer is raised, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strm_valid | input | 1 | Pushes `strm_addr` into the address queue |
| strm_restart | input | 1 | With `strm_valid`: this address opens a new stream |
| strm_addr | input | AW | Predicted block address |
| lk_valid | input | 1 | Processor lookup request |
| lk_addr | input | AW | Lookup block address |
| lk_hit | output | 1 | Lookup found filled data (one cycle after request) |
| lk_pend | output | 1 | Lookup matched a fetch still in flight |
| lk_miss | output | 1 | Lookup matched nothing |
| lk_data | output | DW | Data returned with `lk_hit` |
| mem_req_valid | output | 1 | Fetch request pulse |
| mem_req_addr | output | AW | Block address to fetch |
| mem_req_tag | output | log2(ENTRIES) | Slot the fill must return to |
| mem_fill_valid | input | 1 | Fill data returning from memory |
| mem_fill_tag | input | log2(ENTRIES) | Slot of the returning fill |
| mem_fill_data | input | DW | Fetched block data |

## Verification
The embedded properties assume that memory answers each request exactly once, with the tag it was given, and never sends a fill for a slot that has no request outstanding. They also assume that no stream pushes an address that the buffer already holds, so a lookup matches at most one slot. The bench's memory model is a fixed-latency pipe that echoes each request's tag once. Every scenario draws its addresses from a disjoint range, and each scenario starts from reset, so no address repeats while it may still be buffered.

// File: rtl/spb_pkg.sv
package spb_pkg;
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_HIT  = 2'd1,
      LK_PEND = 2'd2,
      LK_MISS = 2'd3
   } lk_res_e;
endpackage

// File: rtl/spb_addr_fifo.sv
module spb_addr_fifo #(
   parameter int AW    = 32,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          restart,
   input  logic [AW-1:0] push_addr,
   input  logic          pop,
   output logic          empty,
   output logic [AW-1:0] head
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("spb_addr_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [AW-1:0] slots [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [PW:0]   cnt;
   logic          full, do_push, do_pop;

   assign full    = (cnt == (PW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign head    = slots[rd_ptr];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (push && restart) begin
         slots[0] <= push_addr;
         rd_ptr   <= '0;
         wr_ptr   <= PW'(1);
         cnt      <= (PW+1)'(1);
      end else begin
         if (do_push) begin
            slots[wr_ptr] <= push_addr;
            wr_ptr        <= wr_ptr + PW'(1);
         end
         if (do_pop) rd_ptr <= rd_ptr + PW'(1);
         cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
      end
   end

   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push && restart |=> cnt == (PW+1)'(1) && head == $past(push_addr));

   p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !restart && !pop |=> full && $stable(wr_ptr));
endmodule

// File: rtl/spb_age_victim.sv
module spb_age_victim #(
   parameter int N = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc,
   input  logic [$clog2(N)-1:0] alloc_idx,
   input  logic [N-1:0]         occupied,
   input  logic [N-1:0]         filled,
   output logic [$clog2(N)-1:0] victim,
   output logic                 victim_ok
);
   localparam int IW = $clog2(N);

   logic [N-1:0] older [N];   // older[i][j]: slot i allocated before slot j
   logic [N-1:0] cand;
   logic [N-1:0] free_v;
   logic [IW-1:0] free_idx, old_idx;

   assign free_v = ~occupied;

   for (genvar i = 0; i < N; i++) begin : g_cand
      assign cand[i] = filled[i] && (&(older[i] | ~filled | (N'(1) << i)));
   end

   always_comb begin
      free_idx = '0;
      old_idx  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_v[i]) free_idx = IW'(i);
         if (cand[i])   old_idx  = IW'(i);
      end
      victim    = (|free_v) ? free_idx : old_idx;
      victim_ok = (|free_v) || (|cand);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) older[i] <= '0;
      end else if (alloc) begin
         for (int j = 0; j < N; j++) begin
            older[alloc_idx][j] <= 1'b0;
            if (IW'(j) != alloc_idx) older[j][alloc_idx] <= 1'b1;
         end
      end
   end

   p_no_inflight_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !(occupied[alloc_idx] && !filled[alloc_idx]));
endmodule

// File: rtl/spb_entry_store.sv
module spb_entry_store #(
   parameter int N  = 32,
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc,
   input  logic [$clog2(N)-1:0]   alloc_idx,
   input  logic [AW-1:0]          alloc_addr,
   input  logic                   fill_valid,
   input  logic [$clog2(N)-1:0]   fill_tag,
   input  logic [DW-1:0]          fill_data,
   input  logic                   stale_all,
   input  logic                   take,
   input  logic [AW-1:0]          lk_addr,
   output logic                   match_fill,
   output logic                   match_pend,
   output logic [$clog2(N)-1:0]   match_idx,
   output logic [DW-1:0]          match_data,
   output logic [N-1:0]           occupied,
   output logic [N-1:0]           filled_o,
   output logic [$clog2(N+1)-1:0] used
);
   localparam int IW = $clog2(N);
   localparam int CW = $clog2(N + 1);

   logic [AW-1:0] tag_q  [N];
   logic [DW-1:0] data_q [N];
   logic [N-1:0]  inflight, filled, fresh;

   assign occupied   = inflight | filled;
   assign filled_o   = filled;
   assign match_data = data_q[match_idx];

   always_comb begin
      match_fill = 1'b0;
      match_pend = 1'b0;
      match_idx  = '0;
      used       = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (filled[i] && tag_q[i] == lk_addr) begin
            match_fill = 1'b1;
            match_idx  = IW'(i);
         end
         if (inflight[i] && tag_q[i] == lk_addr) match_pend = 1'b1;
         used = used + CW'(inflight[i]) + CW'(filled[i] & fresh[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight <= '0;
         filled   <= '0;
         fresh    <= '0;
      end else begin
         if (fill_valid) begin
            inflight[fill_tag] <= 1'b0;
            filled[fill_tag]   <= 1'b1;
            data_q[fill_tag]   <= fill_data;
         end
         if (stale_all) fresh <= fresh & ~filled;
         if (take) filled[match_idx] <= 1'b0;
         if (alloc) begin
            inflight[alloc_idx] <= 1'b1;
            filled[alloc_idx]   <= 1'b0;
            fresh[alloc_idx]    <= 1'b1;
            tag_q[alloc_idx]    <= alloc_addr;
         end
      end
   end

   p_fill_expected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> inflight[fill_tag]);

   p_take_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take && !(alloc && alloc_idx == match_idx) |=> !filled[$past(match_idx)]);
endmodule

// File: rtl/stream_prefetch_buffer.sv
module stream_prefetch_buffer
   import spb_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int QUEUE_DEPTH = 16,
   parameter int ENTRIES     = 32,
   parameter int LOOKAHEAD   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       strm_valid,
   input  logic                       strm_restart,
   input  logic [AW-1:0]              strm_addr,
   input  logic                       lk_valid,
   input  logic [AW-1:0]              lk_addr,
   output logic                       lk_hit,
   output logic                       lk_pend,
   output logic                       lk_miss,
   output logic [DW-1:0]              lk_data,
   output logic                       mem_req_valid,
   output logic [AW-1:0]              mem_req_addr,
   output logic [$clog2(ENTRIES)-1:0] mem_req_tag,
   input  logic                       mem_fill_valid,
   input  logic [$clog2(ENTRIES)-1:0] mem_fill_tag,
   input  logic [DW-1:0]              mem_fill_data
);
   localparam int IW = $clog2(ENTRIES);
   localparam int CW = $clog2(ENTRIES + 1);

   if (ENTRIES < 2 || LOOKAHEAD < 1 || LOOKAHEAD > ENTRIES) begin : g_bad_cfg
      $error("stream_prefetch_buffer: need ENTRIES >= 2 and 1 <= LOOKAHEAD <= ENTRIES");
   end

   logic          q_empty, restart_now, issue, take;
   logic [AW-1:0] q_head;
   logic          victim_ok, match_fill, match_pend;
   logic [IW-1:0] victim, match_idx;
   logic [DW-1:0] match_data;
   logic [ENTRIES-1:0] occupied, filled;
   logic [CW-1:0] used;
   lk_res_e       res_q;

   assign restart_now = strm_valid && strm_restart;
   assign issue = !q_empty && !restart_now && victim_ok && (used < CW'(LOOKAHEAD));
   assign take  = lk_valid && match_fill;

   spb_addr_fifo #(.AW(AW), .DEPTH(QUEUE_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(strm_valid), .restart(strm_restart),
      .push_addr(strm_addr), .pop(issue), .empty(q_empty), .head(q_head));

   spb_age_victim #(.N(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .alloc(issue), .alloc_idx(victim),
      .occupied(occupied), .filled(filled), .victim(victim), .victim_ok(victim_ok));

   spb_entry_store #(.N(ENTRIES), .AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .alloc(issue), .alloc_idx(victim),
      .alloc_addr(q_head), .fill_valid(mem_fill_valid), .fill_tag(mem_fill_tag),
      .fill_data(mem_fill_data), .stale_all(restart_now), .take(take),
      .lk_addr(lk_addr), .match_fill(match_fill), .match_pend(match_pend),
      .match_idx(match_idx), .match_data(match_data), .occupied(occupied),
      .filled_o(filled), .used(used));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q         <= LK_IDLE;
         lk_data       <= '0;
         mem_req_valid <= 1'b0;
         mem_req_addr  <= '0;
         mem_req_tag   <= '0;
      end else begin
         if (!lk_valid)       res_q <= LK_IDLE;
         else if (match_fill) res_q <= LK_HIT;
         else if (match_pend) res_q <= LK_PEND;
         else                 res_q <= LK_MISS;
         if (take) lk_data <= match_data;
         mem_req_valid <= issue;
         if (issue) begin
            mem_req_addr <= q_head;
            mem_req_tag  <= victim;
         end
      end
   end

   assign lk_hit  = (res_q == LK_HIT);
   assign lk_pend = (res_q == LK_PEND);
   assign lk_miss = (res_q == LK_MISS);

   p_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CW'(LOOKAHEAD));

   p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> $onehot({lk_hit, lk_pend, lk_miss}));

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !lk_hit && !lk_pend && !lk_miss);

   p_no_issue_on_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      restart_now |=> !mem_req_valid);
endmodule

// File: tb/stream_prefetch_buffer_tb.sv
`timescale 1ns/1ps
module stream_prefetch_buffer_tb;
   localparam int AW = 32, DW = 32, ENT = 32, IW = 5, LAT = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic strm_valid = 0, strm_restart = 0, lk_valid = 0;
   logic [AW-1:0] strm_addr = '0, lk_addr = '0;
   logic lk_hit, lk_pend, lk_miss, mem_req_valid;
   logic [DW-1:0] lk_data;
   logic [AW-1:0] mem_req_addr;
   logic [IW-1:0] mem_req_tag;
   logic mem_fill_valid = 0;
   logic [IW-1:0] mem_fill_tag = '0;
   logic [DW-1:0] mem_fill_data = '0;

   int n_tests = 0, n_fail = 0, req_n = 0;
   logic [AW-1:0] req_log [128];

   always #4 clk = ~clk;

   stream_prefetch_buffer #(.AW(AW), .DW(DW), .QUEUE_DEPTH(16), .ENTRIES(ENT), .LOOKAHEAD(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .strm_valid(strm_valid), .strm_restart(strm_restart),
      .strm_addr(strm_addr), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
      .lk_pend(lk_pend), .lk_miss(lk_miss), .lk_data(lk_data), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag), .mem_fill_valid(mem_fill_valid),
      .mem_fill_tag(mem_fill_tag), .mem_fill_data(mem_fill_data));

   function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
      return a ^ 32'hC3A5_0F1E;
   endfunction

   // fixed-latency memory and request log
   initial begin : responder
      logic          pv [LAT];
      logic [IW-1:0] pt [LAT];
      logic [AW-1:0] pa [LAT];
      for (int i = 0; i < LAT; i++) pv[i] = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pv[i] = 1'b0;
            mem_fill_valid = 1'b0;
         end else begin
            mem_fill_valid = pv[LAT-1];
            mem_fill_tag   = pt[LAT-1];
            mem_fill_data  = fdata(pa[LAT-1]);
            for (int i = LAT - 1; i > 0; i--) begin
               pv[i] = pv[i-1]; pt[i] = pt[i-1]; pa[i] = pa[i-1];
            end
            pv[0] = mem_req_valid; pt[0] = mem_req_tag; pa[0] = mem_req_addr;
            if (mem_req_valid) begin
               if (req_n < 128) req_log[req_n] = mem_req_addr;
               req_n = req_n + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; strm_valid = 0; lk_valid = 0;
      settle(3);
      rst_n = 1;
      settle(1);
   endtask

   task automatic push(input logic [AW-1:0] a, input bit rs);
      strm_valid = 1; strm_restart = rs; strm_addr = a;
      @(negedge clk);
      strm_valid = 0; strm_restart = 0;
   endtask

   // result: 0 miss, 1 hit, 2 pend
   task automatic lookup(input logic [AW-1:0] a, input int exp_kind, input string req);
      int kind;
      lk_valid = 1; lk_addr = a;
      @(negedge clk);
      lk_valid = 0;
      kind = lk_hit ? 1 : lk_pend ? 2 : lk_miss ? 0 : 9;
      chk(kind == exp_kind && $countones({lk_hit, lk_pend, lk_miss}) == 1, req, 64'(kind), 64'(exp_kind));
      if (exp_kind == 1 && kind == 1) chk(lk_data == fdata(a), req, 64'(lk_data), 64'(fdata(a)));
   endtask

   task automatic t_reset();
      do_reset();
      chk(!mem_req_valid && !lk_hit && !lk_pend && !lk_miss, "R10 idle outputs",
          64'({mem_req_valid, lk_hit, lk_pend, lk_miss}), 64'd0);
      lookup(32'h55, 0, "R10 lookup after reset");
      settle(5);
      chk(req_n == 0, "R10 no requests", 64'(req_n), 64'd0);
   endtask

   task automatic t_pending();
      do_reset();
      lookup(32'h999, 0, "R7 unknown address");
      push(32'h777, 1);
      while (!mem_req_valid) @(negedge clk);
      chk(mem_req_addr == 32'h777, "R1 single request", 64'(mem_req_addr), 64'h777);
      lookup(32'h777, 2, "R6 pending while in flight");
      settle(12);
      lookup(32'h777, 1, "R6 hit after fill");
      lookup(32'h777, 0, "R5 entry removed by hit");
   endtask

   task automatic t_lookahead();
      int base, i;
      do_reset();
      base = req_n;
      for (int k = 0; k < 12; k++) push(32'h100 + AW'(k), k == 0);
      settle(20);
      chk(req_n - base == 8, "R4 stall at lookahead", 64'(req_n - base), 64'd8);
      for (int k = 0; k < 14; k++) push(32'h200 + AW'(k), 0);
      settle(10);
      chk(req_n - base == 8, "R4 still stalled", 64'(req_n - base), 64'd8);
      lookup(req_log[base], 1, "R4 hit releases budget");
      settle(10);
      chk(req_n - base == 9, "R4 one more request", 64'(req_n - base), 64'd9);
      i = 1;
      while (i < req_n - base && i < 40) begin
         lookup(req_log[base + i], 1, "R5 consume streamed block");
         settle(10);
         i++;
      end
      chk(req_n - base == 24, "R3 overflow pushes dropped", 64'(req_n - base), 64'd24);
      for (int k = 0; k < 24; k++) begin
         logic [AW-1:0] e;
         e = (k < 12) ? 32'h100 + AW'(k) : 32'h200 + AW'(k - 12);
         chk(req_log[base + k] == e, "R1 issue order", 64'(req_log[base + k]), 64'(e));
      end
   endtask

   task automatic t_flush();
      int base;
      do_reset();
      base = req_n;
      for (int k = 0; k < 12; k++) push(32'h300 + AW'(k), k == 0);
      settle(20);
      push(32'h400, 1);
      push(32'h401, 0);
      settle(20);
      chk(req_n - base == 10, "R2 queued tail discarded", 64'(req_n - base), 64'd10);
      chk(req_log[base + 8] == 32'h400, "R2 new stream first", 64'(req_log[base + 8]), 64'h400);
      chk(req_log[base + 9] == 32'h401, "R2 new stream second", 64'(req_log[base + 9]), 64'h401);
      lookup(32'h300, 1, "R9 older stream entry still hits");
   endtask

   task automatic t_evict();
      int base;
      do_reset();
      base = req_n;
      for (int s = 0; s < 5; s++) begin
         for (int k = 0; k < 8; k++) push(32'h1000 * AW'(s + 1) + AW'(k), k == 0);
         settle(20);
         chk(req_n - base == 8 * (s + 1), "R9 restart frees budget", 64'(req_n - base), 64'(8 * (s + 1)));
      end
      lookup(32'h1000, 0, "R8 oldest entry replaced");
      lookup(32'h1007, 0, "R8 oldest stream fully replaced");
      lookup(32'h2000, 1, "R8 next oldest retained");
      lookup(32'h4007, 1, "R9 stale entry hits");
      lookup(32'h5003, 1, "R8 newest stream present");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_pending();
      t_lookahead();
      t_flush();
      t_evict();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule